// File: doc/BRIEF.md
# Load/Store Port Protocol Monitor

This block sits beside a single-request load/store port that joins an execution unit to a memory back end. It drives nothing on that port. Each cycle it looks at the request strobes and the address lines from the requester, and at the busy, address-accept, fault, load-valid and store-valid lines from the back end. It follows every transaction from idle through open and address accepted to its end, and it records any breach of the handshake in its own sticky error bit. Only timing and ordering are checked. Data values are never examined.

Each rule has its own error bit, and a single summary flag gives the OR of all of them. A counter records the transactions that finished cleanly, so a test can confirm that real traffic went through and not only that no rule was broken. The main point of the rules is that busy must drop at different times. It drops in the same cycle as load data or a fault, and one cycle after the store-data strobe.

Top module: `ldst_port_monitor`

## Requirements
- R1: A synchronous active-high `rst` returns the monitor to idle and clears `rule_err`, `any_err` and `txn_count` at the next clock edge.
- R2: `rule_err[0]` is set when `ld_req` or `st_req` is high while `port_busy` is high, or while a transaction is still open. A request is accepted only from idle with busy low.
- R3: `rule_err[1]` is set when `ld_req` and `st_req` are high in the same cycle. No transaction starts in that case.
- R4: `rule_err[2]` is set when `port_busy` is low in a cycle where an open transaction has no legal ending. This covers the cycle right after the request. The legal endings are a fault, or load data on an accepted load.
- R5: `rule_err[3]` is set when, after `adr_valid` was seen high with busy high in a transaction, `adr_valid` falls or `adr` changes while `port_busy` is still high.
- R6: `rule_err[4]` is set when `adr_accept` or `fault` appears outside the first phase of a transaction. This covers idle, a second accept, a fault after an accept, both in one cycle, or either on two cycles in a row.
- R7: `rule_err[5]` is set whenever `fault` and `port_busy` are high in the same cycle.
- R8: `rule_err[6]` is set when `ld_valid` is high in any case other than the single cycle that ends an accepted load with `port_busy` low.
- R9: `rule_err[7]` is set when `st_valid` is high other than once after an accepted store while busy is high. It is also set when `port_busy` is still high in the cycle after `st_valid`.
- R10: Each error bit becomes visible in the cycle after the breach and stays set until reset. `any_err` equals the OR of `rule_err` at all times.
- R11: `txn_count` rises by one in the cycle after a clean end. A clean end is the load-data cycle of a load, or the cycle after `st_valid` for a store. A transaction ended by a fault, or one in which any rule fired, is not counted.
- R12: A legal load, a legal store and a legal faulted request raise no error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request strobe from the requester |
| st_req | input | 1 | Store request strobe from the requester |
| adr_valid | input | 1 | Address valid from the requester |
| adr | input | ADDR_W | Request address |
| port_busy | input | 1 | Busy from the back end |
| adr_accept | input | 1 | Address-accept pulse from the back end |
| fault | input | 1 | Fault pulse from the back end |
| ld_valid | input | 1 | Load-data-valid pulse from the back end |
| st_valid | input | 1 | Store-data-valid pulse from the requester |
| rule_err | output | 8 | Sticky per-rule error bits, bit n as listed in R2 to R9 |
| any_err | output | 1 | OR of all error bits |
| txn_count | output | CNT_W | Count of cleanly completed transactions |

## Verification
The properties assume the inputs are clean binary values on every clock edge. They also assume reset is held for at least one edge before any traffic starts, so that sticky flags and the counter have a known starting point. The stimulus changes inputs only on the falling edge and returns every line to zero during reset rows. Each breach is set up inside its own short sequence that begins from idle, so a rule fires without side effects carried over from an earlier transaction.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

  localparam int NUM_RULES       = 8;
  localparam int RULE_REQ_BUSY   = 0;
  localparam int RULE_DUAL_REQ   = 1;
  localparam int RULE_BUSY_SHAPE = 2;
  localparam int RULE_ADDR_HOLD  = 3;
  localparam int RULE_ACCEPT     = 4;
  localparam int RULE_FAULT_BUSY = 5;
  localparam int RULE_LOAD_END   = 6;
  localparam int RULE_STORE_END  = 7;

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_OPEN     = 2'd1,
    S_ACCEPTED = 2'd2,
    S_ST_TAIL  = 2'd3
  } mon_state_e;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mon_op_e;

endpackage

// File: rtl/ldst_txn_fsm.sv
module ldst_txn_fsm
  import ldst_mon_pkg::*;
#(
  parameter int NR = NUM_RULES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          port_busy,
  input  logic          adr_accept,
  input  logic          fault,
  input  logic          ld_valid,
  input  logic          st_valid,
  input  logic [NR-1:0] other_viol,
  output logic [NR-1:0] seq_viol,
  output logic          txn_open,
  output logic          clean_done
);

  mon_state_e state_q, state_d;
  mon_op_e    op_q, op_d;
  logic       dirty_q, dirty_d;
  logic       end_evt;
  logic       req_any;
  logic [NR-1:0] all_viol;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    seq_viol = '0;
    end_evt  = 1'b0;
    req_any  = ld_req | st_req;

    // rules that hold in every state
    seq_viol[RULE_REQ_BUSY]   = req_any && (port_busy || (state_q != S_IDLE));
    seq_viol[RULE_DUAL_REQ]   = ld_req && st_req;
    seq_viol[RULE_FAULT_BUSY] = fault && port_busy;

    unique case (state_q)
      S_IDLE: begin
        if (adr_accept || fault) seq_viol[RULE_ACCEPT]    = 1'b1;
        if (ld_valid)            seq_viol[RULE_LOAD_END]  = 1'b1;
        if (st_valid)            seq_viol[RULE_STORE_END] = 1'b1;
        if (req_any && !(ld_req && st_req) && !port_busy) begin
          state_d = S_OPEN;
          op_d    = st_req ? OP_STORE : OP_LOAD;
        end
      end

      S_OPEN: begin
        if (ld_valid)              seq_viol[RULE_LOAD_END]  = 1'b1;
        if (st_valid)              seq_viol[RULE_STORE_END] = 1'b1;
        if (adr_accept && fault)   seq_viol[RULE_ACCEPT]    = 1'b1;
        if (fault) begin
          state_d = S_IDLE;
        end else if (!port_busy) begin
          seq_viol[RULE_BUSY_SHAPE] = 1'b1;
          state_d = S_IDLE;
        end else if (adr_accept) begin
          state_d = S_ACCEPTED;
        end
      end

      S_ACCEPTED: begin
        if (adr_accept) seq_viol[RULE_ACCEPT] = 1'b1;
        if (ld_valid && (op_q != OP_LOAD))  seq_viol[RULE_LOAD_END]  = 1'b1;
        if (st_valid && (op_q != OP_STORE)) seq_viol[RULE_STORE_END] = 1'b1;
        if (fault) begin
          seq_viol[RULE_ACCEPT] = 1'b1;
          state_d = S_IDLE;
        end else if ((op_q == OP_LOAD) && ld_valid) begin
          if (port_busy) seq_viol[RULE_LOAD_END] = 1'b1;
          end_evt = 1'b1;
          state_d = S_IDLE;
        end else if (!port_busy) begin
          seq_viol[RULE_BUSY_SHAPE] = 1'b1;
          state_d = S_IDLE;
        end else if ((op_q == OP_STORE) && st_valid) begin
          state_d = S_ST_TAIL;
        end
      end

      S_ST_TAIL: begin
        if (st_valid || port_busy) seq_viol[RULE_STORE_END] = 1'b1;
        if (adr_accept || fault)   seq_viol[RULE_ACCEPT]    = 1'b1;
        if (ld_valid)              seq_viol[RULE_LOAD_END]  = 1'b1;
        end_evt = 1'b1;
        state_d = S_IDLE;
      end

      default: state_d = S_IDLE;
    endcase
  end

  assign all_viol   = seq_viol | other_viol;
  assign dirty_d    = (state_q == S_IDLE) ? (|all_viol) : (dirty_q | (|all_viol));
  assign clean_done = end_evt && !dirty_q && (all_viol == '0);
  assign txn_open   = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      op_q    <= OP_LOAD;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      dirty_q <= dirty_d;
    end
  end

endmodule

// File: rtl/ldst_addr_hold.sv
module ldst_addr_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_open,
  input  logic          port_busy,
  input  logic          adr_valid,
  input  logic [AW-1:0] adr,
  output logic          hold_viol
);

  logic          held_q;
  logic [AW-1:0] adr_q;

  assign hold_viol = txn_open && port_busy && held_q &&
                     (!adr_valid || (adr != adr_q));

  always_ff @(posedge clk) begin
    if (rst || !txn_open) begin
      held_q <= 1'b0;
    end else if (port_busy && adr_valid && !held_q) begin
      held_q <= 1'b1;
    end
  end

  // captured value needs no reset: it is qualified by held_q
  always_ff @(posedge clk) begin
    if (txn_open && port_busy && adr_valid && !held_q) adr_q <= adr;
  end

endmodule

// File: rtl/ldst_err_bank.sv
module ldst_err_bank #(
  parameter int NR = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NR-1:0] viol,
  input  logic          clean_done,
  output logic [NR-1:0] rule_err,
  output logic          any_err,
  output logic [CW-1:0] txn_count
);

  for (genvar g = 0; g < NR; g++) begin : g_flag
    logic sticky_q;
    always_ff @(posedge clk) begin
      if (rst)          sticky_q <= 1'b0;
      else if (viol[g]) sticky_q <= 1'b1;
    end
    assign rule_err[g] = sticky_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_err   <= 1'b0;
      txn_count <= '0;
    end else begin
      any_err <= |(rule_err | viol);
      if (clean_done) txn_count <= txn_count + 1'b1;
    end
  end

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
  import ldst_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_req,
  input  logic                 st_req,
  input  logic                 adr_valid,
  input  logic [ADDR_W-1:0]    adr,
  input  logic                 port_busy,
  input  logic                 adr_accept,
  input  logic                 fault,
  input  logic                 ld_valid,
  input  logic                 st_valid,
  output logic [NUM_RULES-1:0] rule_err,
  output logic                 any_err,
  output logic [CNT_W-1:0]     txn_count
);

  logic [NUM_RULES-1:0] seq_viol;
  logic [NUM_RULES-1:0] addr_viol;
  logic                 hold_viol;
  logic                 txn_open;
  logic                 clean_done;

  always_comb begin
    addr_viol = '0;
    addr_viol[RULE_ADDR_HOLD] = hold_viol;
  end

  ldst_txn_fsm #(.NR(NUM_RULES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ld_req     (ld_req),
    .st_req     (st_req),
    .port_busy  (port_busy),
    .adr_accept (adr_accept),
    .fault      (fault),
    .ld_valid   (ld_valid),
    .st_valid   (st_valid),
    .other_viol (addr_viol),
    .seq_viol   (seq_viol),
    .txn_open   (txn_open),
    .clean_done (clean_done)
  );

  ldst_addr_hold #(.AW(ADDR_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .txn_open  (txn_open),
    .port_busy (port_busy),
    .adr_valid (adr_valid),
    .adr       (adr),
    .hold_viol (hold_viol)
  );

  ldst_err_bank #(.NR(NUM_RULES), .CW(CNT_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .viol       (seq_viol | addr_viol),
    .clean_done (clean_done),
    .rule_err   (rule_err),
    .any_err    (any_err),
    .txn_count  (txn_count)
  );

endmodule

// File: rtl/ldst_port_monitor_chk.sv
module ldst_port_monitor_chk
  import ldst_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ld_req,
  input logic                 st_req,
  input logic                 port_busy,
  input logic                 fault,
  input logic [NUM_RULES-1:0] rule_err,
  input logic                 any_err,
  input logic [CNT_W-1:0]     txn_count
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (rule_err == '0) && !any_err && (txn_count == '0));

  p_req_busy_r2: assert property (@(posedge clk) disable iff (rst)
    ((ld_req || st_req) && port_busy) |=> rule_err[RULE_REQ_BUSY]);

  p_dual_req_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_req && st_req) |=> rule_err[RULE_DUAL_REQ]);

  p_fault_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (fault && port_busy) |=> rule_err[RULE_FAULT_BUSY]);

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rule_err & $past(rule_err)) == $past(rule_err)));

  p_any_is_or_r10: assert property (@(posedge clk) disable iff (rst)
    any_err == (rule_err != '0));

  p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((txn_count == $past(txn_count)) ||
                     (txn_count == CNT_W'($past(txn_count) + 1'b1))));

endmodule

bind ldst_port_monitor ldst_port_monitor_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_req    (ld_req),
  .st_req    (st_req),
  .port_busy (port_busy),
  .fault     (fault),
  .rule_err  (rule_err),
  .any_err   (any_err),
  .txn_count (txn_count)
);

// File: tb/test_ldst_port_monitor.sv
module test_ldst_port_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int CNT_W      = 16;

  // ctl = {rst, ld_req, st_req, adr_valid}
  // bk  = {port_busy, adr_accept, fault, ld_valid, st_valid}
  typedef struct packed {
    logic [3:0] ctl;
    logic [7:0] a;
    logic [4:0] bk;
    logic [7:0] ef;
    logic [3:0] cnt;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t TBL [NV] = '{
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 0  R1 reset
    '{4'b0000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd12},  // 1  idle
    '{4'b0101, 8'h10, 5'b00000, 8'h00, 4'd0, 4'd12},  // 2  R12 load request
    '{4'b0001, 8'h10, 5'b10000, 8'h00, 4'd0, 4'd12},  // 3  busy rises
    '{4'b0001, 8'h10, 5'b11000, 8'h00, 4'd0, 4'd12},  // 4  accept
    '{4'b0001, 8'h10, 5'b10000, 8'h00, 4'd0, 4'd12},  // 5  wait
    '{4'b0001, 8'h10, 5'b00010, 8'h00, 4'd1, 4'd11},  // 6  R11 load data, busy low
    '{4'b0000, 8'h00, 5'b00000, 8'h00, 4'd1, 4'd11},  // 7
    '{4'b0011, 8'h20, 5'b00000, 8'h00, 4'd1, 4'd12},  // 8  store request
    '{4'b0001, 8'h20, 5'b11000, 8'h00, 4'd1, 4'd12},  // 9  busy + accept
    '{4'b0001, 8'h20, 5'b10001, 8'h00, 4'd1, 4'd12},  // 10 store data
    '{4'b0001, 8'h20, 5'b00000, 8'h00, 4'd2, 4'd11},  // 11 R11 busy drops one later
    '{4'b0000, 8'h00, 5'b00000, 8'h00, 4'd2, 4'd12},  // 12
    '{4'b0101, 8'h30, 5'b00000, 8'h00, 4'd2, 4'd12},  // 13 faulted load
    '{4'b0001, 8'h30, 5'b10000, 8'h00, 4'd2, 4'd12},  // 14
    '{4'b0001, 8'h30, 5'b00100, 8'h00, 4'd2, 4'd11},  // 15 R11 fault not counted
    '{4'b0000, 8'h00, 5'b00000, 8'h00, 4'd2, 4'd12},  // 16
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 17 R1
    '{4'b0110, 8'h00, 5'b00000, 8'h02, 4'd0, 4'd3 },  // 18 R3 dual request
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 19
    '{4'b0101, 8'h40, 5'b00000, 8'h00, 4'd0, 4'd4 },  // 20
    '{4'b0001, 8'h40, 5'b00000, 8'h04, 4'd0, 4'd4 },  // 21 R4 busy missing
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 22
    '{4'b0011, 8'h50, 5'b00000, 8'h00, 4'd0, 4'd5 },  // 23
    '{4'b0001, 8'h50, 5'b10000, 8'h00, 4'd0, 4'd5 },  // 24
    '{4'b0001, 8'h51, 5'b10000, 8'h08, 4'd0, 4'd5 },  // 25 R5 address changed
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 26
    '{4'b0101, 8'h60, 5'b00000, 8'h00, 4'd0, 4'd6 },  // 27
    '{4'b0001, 8'h60, 5'b11000, 8'h00, 4'd0, 4'd6 },  // 28
    '{4'b0001, 8'h60, 5'b11000, 8'h10, 4'd0, 4'd6 },  // 29 R6 accept twice
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 30
    '{4'b0101, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd7 },  // 31
    '{4'b0001, 8'h00, 5'b10100, 8'h20, 4'd0, 4'd7 },  // 32 R7 fault with busy
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 33
    '{4'b0101, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd8 },  // 34
    '{4'b0001, 8'h00, 5'b11000, 8'h00, 4'd0, 4'd8 },  // 35
    '{4'b0001, 8'h00, 5'b10010, 8'h40, 4'd0, 4'd8 },  // 36 R8 load data with busy
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 37
    '{4'b0011, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd9 },  // 38
    '{4'b0001, 8'h00, 5'b10001, 8'h80, 4'd0, 4'd9 },  // 39 R9 store data before accept
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 40
    '{4'b0011, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd9 },  // 41
    '{4'b0001, 8'h00, 5'b11000, 8'h00, 4'd0, 4'd9 },  // 42
    '{4'b0001, 8'h00, 5'b10001, 8'h00, 4'd0, 4'd9 },  // 43
    '{4'b0001, 8'h00, 5'b10000, 8'h80, 4'd0, 4'd9 },  // 44 R9 busy stays after store data
    '{4'b1000, 8'h00, 5'b00000, 8'h00, 4'd0, 4'd1 },  // 45
    '{4'b0101, 8'h70, 5'b00000, 8'h00, 4'd0, 4'd2 },  // 46
    '{4'b0001, 8'h70, 5'b10000, 8'h00, 4'd0, 4'd2 },  // 47
    '{4'b0101, 8'h70, 5'b10000, 8'h01, 4'd0, 4'd2 }   // 48 R2 request while busy
  };

  logic              clk = 1'b0;
  logic              rst, ld_req, st_req, adr_valid;
  logic [ADDR_W-1:0] adr;
  logic              port_busy, adr_accept, fault, ld_valid, st_valid;
  logic [7:0]        rule_err;
  logic              any_err;
  logic [CNT_W-1:0]  txn_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_port_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ldst_port_monitor (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req),
    .adr_valid(adr_valid), .adr(adr), .port_busy(port_busy),
    .adr_accept(adr_accept), .fault(fault), .ld_valid(ld_valid),
    .st_valid(st_valid), .rule_err(rule_err), .any_err(any_err),
    .txn_count(txn_count)
  );

  task automatic drive(input logic [3:0] ctl, input logic [7:0] a, input logic [4:0] bk);
    {rst, ld_req, st_req, adr_valid} = ctl;
    adr = {{(ADDR_W-8){1'b0}}, a};
    {port_busy, adr_accept, fault, ld_valid, st_valid} = bk;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // one step: drive at the falling edge, outputs settle after the rising edge
  task automatic step(input logic [3:0] ctl, input logic [7:0] a, input logic [4:0] bk);
    drive(ctl, a, bk);
    @(negedge clk);
  endtask

  initial begin
    drive(4'b1000, 8'h00, 5'b00000);
    @(negedge clk);
    @(negedge clk);
    check("R1 reset flags", int'(rule_err), 0);
    check("R1 reset count", int'(txn_count), 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ctl, TBL[i].a, TBL[i].bk);
      check($sformatf("R%0d row %0d flags", TBL[i].rq, i), int'(rule_err), int'(TBL[i].ef));
      check($sformatf("R%0d row %0d count", TBL[i].rq, i), int'(txn_count[3:0]), int'(TBL[i].cnt));
      check($sformatf("R10 row %0d any", i), int'(any_err), int'(TBL[i].ef != 8'h00));
    end

    // R10: flags persist while the transaction continues legally
    step(4'b0001, 8'h70, 5'b10000);
    step(4'b0001, 8'h70, 5'b10000);
    check("R10 sticky flag", int'(rule_err), 8'h01);
    check("R10 any stays", int'(any_err), 1);

    // R1: reset clears everything
    step(4'b1000, 8'h00, 5'b00000);
    check("R1 flags cleared", int'(rule_err), 0);
    check("R1 any cleared", int'(any_err), 0);

    // R8: load data with nothing open
    step(4'b0000, 8'h00, 5'b00010);
    check("R8 load data in idle", int'(rule_err), 8'h40);
    step(4'b1000, 8'h00, 5'b00000);

    // R11: load with address dropped early is flagged and not counted
    step(4'b0101, 8'h05, 5'b00000);
    step(4'b0001, 8'h05, 5'b10000);
    step(4'b0001, 8'h05, 5'b11000);
    step(4'b0000, 8'h05, 5'b10000);
    check("R5 valid dropped", int'(rule_err), 8'h08);
    step(4'b0000, 8'h05, 5'b00010);
    check("R11 dirty load not counted", int'(txn_count), 0);
    check("R11 dirty load flags", int'(rule_err), 8'h08);
    step(4'b1000, 8'h00, 5'b00000);

    // R6: fault on two cycles in a row
    step(4'b0101, 8'h00, 5'b00000);
    step(4'b0001, 8'h00, 5'b10000);
    step(4'b0001, 8'h00, 5'b00100);
    check("R6 single fault clean", int'(rule_err), 0);
    step(4'b0000, 8'h00, 5'b00100);
    check("R6 repeated fault", int'(rule_err), 8'h10);

    step(4'b1000, 8'h00, 5'b00000);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule